// File: doc/BRIEF.md
# Vector Segment Store Interleaver

This block converts field-major vector register data into struct-major memory order for segment stores. A structure array with NF fields is held in NF source registers. Field i of every structure sits in source register i. To store the array as packed structures, each output register image must hold elements from all fields in rotation: field 0 of structure s, field 1 of structure s, and so on up to field NF-1, then field 0 of structure s+1. Such an image can then be written to memory as one contiguous run of bytes.

A store sequencer pulses `start` once per output chunk. With the pulse it supplies the field count code, the element width code, the element count E and the output chunk index f. The block then copies one element per clock into its output image. When the image is complete it raises `done` for one cycle. For a chunk f, the first element comes from a source register and element position computed from f·E. After that, the source selector rotates through the fields and steps to the next element position each time it wraps. The source images must stay unchanged while `busy` is high.

Top module: `seg_store_interleaver`

## Requirements
- R1: The field count NF is `nf_code` + 1. Legal `nf_code` values are 1 to 7, which give NF from 2 to 8. Source register i sits at bits [i*VREG_BITS +: VREG_BITS] of `src_regs`.
- R2: `width_code` selects the element size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Elements are little-endian byte groups: element j of a register occupies bytes j*size to j*size+size-1.
- R3: Output element 0 of chunk f is taken from source register (f·E) mod NF.
- R4: Output element 0 of chunk f is taken from element position (f·E) div NF of that source register.
- R5: After each element the source register number increases by one. When it reaches NF it wraps to 0, and the element position then increases by one. Equivalently, output element k of chunk f comes from register (f·E+k) mod NF at position (f·E+k) div NF.
- R6: Output element k is placed at element slot k of `out_reg`. Slots are filled in ascending order, one per clock.
- R7: An accepted start clears `out_reg` to zero. Byte lanes beyond the first E elements stay zero.
- R8: `done` is high for exactly one cycle. It occurs E clocks after the clock edge that accepts `start`. When E is 0 it occurs on the following clock with an all-zero image. `busy` is high from the accepting edge until the final copy, and `busy` and `done` are never high together.
- R9: A `start` pulse while `busy` is high is ignored. The running chunk completes with its original parameters and timing.
- R10: While idle, `out_reg` holds its value until the next accepted start.
- R11: After reset, `out_reg` is zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chunk; accepted only when idle |
| nf_code | input | 3 | Field count minus one |
| width_code | input | 2 | Element size code |
| elem_count | input | 5 | Elements E in this chunk (0 to VREG_BITS/8) |
| chunk_idx | input | 3 | Output chunk index f |
| src_regs | input | MAX_FIELDS*VREG_BITS | Source register images, field i at slice i |
| out_reg | output | VREG_BITS | Interleaved output register image |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse when the image is complete |

## Verification
A wrong initial source register or element position shifts every element of the image. This shows up on `out_reg` at the `done` pulse, when the image is compared with the closed-form index mapping. A wrong wrap point in the rotating selector usually leaves the first few elements correct and corrupts the elements after the first wrap. This is why the vectors cover odd field counts and non-zero chunk indices. A wrong element counter shows up as a `done` pulse that arrives too early or too late, or as nonzero bytes past the last element. It is caught on the first chunk, by counting clocks from start to `done`.

// File: rtl/seg_store_interleaver.sv
module seg_store_interleaver #(
  parameter int VREG_BITS  = 128,
  parameter int MAX_FIELDS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [$clog2(MAX_FIELDS)-1:0]   nf_code,
  input  logic [1:0]                      width_code,
  input  logic [$clog2(VREG_BITS/8+1)-1:0] elem_count,
  input  logic [$clog2(MAX_FIELDS)-1:0]   chunk_idx,
  input  logic [MAX_FIELDS*VREG_BITS-1:0] src_regs,
  output logic [VREG_BITS-1:0]            out_reg,
  output logic                            busy,
  output logic                            done
);
  localparam int NBYTES = VREG_BITS / 8;
  localparam int CW     = $clog2(NBYTES + 1);
  localparam int FW     = $clog2(MAX_FIELDS);
  localparam int PW     = FW + CW;

  logic                 busy_q, done_q;
  logic [FW:0]          nf_q;
  logic [3:0]           eb_q;
  logic [CW-1:0]        cnt_q, k_q, idx_q;
  logic [FW-1:0]        sel_q;
  logic [VREG_BITS-1:0] out_q, out_next;

  logic [FW:0]   nf_in;
  logic [PW-1:0] prod;
  logic          accept, last_el, last_sel;

  assign nf_in    = {1'b0, nf_code} + 1'b1;
  assign prod     = PW'(chunk_idx) * PW'(elem_count);
  assign accept   = start && !busy_q;
  assign last_el  = (k_q == cnt_q - 1'b1);
  assign last_sel = ({1'b0, sel_q} == nf_q - 1'b1);

  always_comb begin
    out_next = out_q;
    for (int b = 0; b < 8; b++) begin
      int dst;
      int src;
      dst = int'(k_q) * int'(eb_q) + b;
      src = int'(idx_q) * int'(eb_q) + b;
      if (b < int'(eb_q) && dst < NBYTES && src < NBYTES)
        out_next[dst*8 +: 8] = src_regs[(int'(sel_q)*NBYTES + src)*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      nf_q   <= '0;
      eb_q   <= '0;
      cnt_q  <= '0;
      k_q    <= '0;
      idx_q  <= '0;
      sel_q  <= '0;
      out_q  <= '0;
    end else if (accept) begin
      nf_q   <= nf_in;
      eb_q   <= 4'd1 << width_code;
      cnt_q  <= elem_count;
      k_q    <= '0;
      sel_q  <= FW'(prod % PW'(nf_in));
      idx_q  <= CW'(prod / PW'(nf_in));
      out_q  <= '0;
      busy_q <= (elem_count != '0);
      done_q <= (elem_count == '0);
    end else if (busy_q) begin
      out_q  <= out_next;
      k_q    <= k_q + 1'b1;
      sel_q  <= last_sel ? '0 : sel_q + 1'b1;
      idx_q  <= last_sel ? idx_q + 1'b1 : idx_q;
      busy_q <= !last_el;
      done_q <= last_el;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign out_reg = out_q;
  assign busy    = busy_q;
  assign done    = done_q;

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (out_reg == '0));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(out_reg));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_sel && !last_el && !start) |=> (sel_q == '0 && idx_q == $past(idx_q) + 1'b1));

  p_busy_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_el) |=> busy);
endmodule

// File: tb/seg_store_interleaver_test.sv
module seg_store_interleaver_test;
  localparam int VB = 128;
  localparam int MF = 8;
  localparam int NB = VB / 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] nf_code = 0, chunk_idx = 0;
  logic [1:0] width_code = 0;
  logic [4:0] elem_count = 0;
  logic [MF*VB-1:0] src;
  logic [VB-1:0] out_reg;
  logic busy, done;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  seg_store_interleaver #(.VREG_BITS(VB), .MAX_FIELDS(MF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .nf_code(nf_code),
    .width_code(width_code), .elem_count(elem_count), .chunk_idx(chunk_idx),
    .src_regs(src), .out_reg(out_reg), .busy(busy), .done(done));

  // {nf_code, width_code, E, f}
  localparam logic [12:0] VEC [8] = '{
    {3'd1, 2'd0, 5'd16, 3'd0},
    {3'd1, 2'd0, 5'd16, 3'd1},
    {3'd2, 2'd1, 5'd8,  3'd2},
    {3'd7, 2'd0, 5'd16, 3'd7},
    {3'd4, 2'd2, 5'd4,  3'd3},
    {3'd3, 2'd3, 5'd2,  3'd3},
    {3'd6, 2'd0, 5'd5,  3'd6},
    {3'd5, 2'd1, 5'd3,  3'd4}
  };

  function automatic logic [VB-1:0] model(int nf, int eb, int e, int f);
    logic [VB-1:0] r = '0;
    for (int k = 0; k < e; k++) begin
      int t, s, x;
      t = f * e + k;
      s = t % nf;
      x = t / nf;
      for (int b = 0; b < eb; b++)
        r[(k*eb+b)*8 +: 8] = src[(s*NB + x*eb + b)*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [VB-1:0] act, logic [VB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(int nfc, int wc, int e, int f, string req, bit poke_busy);
    logic [VB-1:0] exp;
    logic [VB-1:0] held;
    int cnt = 0;
    exp = model(nfc + 1, 1 << wc, e, f);
    @(negedge clk);
    nf_code = 3'(nfc); width_code = 2'(wc); elem_count = 5'(e); chunk_idx = 3'(f);
    start = 1;
    @(negedge clk);
    start = 0;
    if (e > 0) check(busy === 1'b1, "R8 busy", VB'(busy), VB'(1));
    while (!done && cnt < 100) begin
      if (poke_busy && cnt == 3) begin
        nf_code = 3'd2; chunk_idx = 3'd1; elem_count = 5'd4; width_code = 2'd2;
        start = 1;
      end
      @(negedge clk);
      start = 0;
      cnt++;
    end
    check(cnt == e, {req, " R8 latency"}, VB'(cnt), VB'(e));
    check(out_reg === exp, {req, " R3 R4 R5 R6 R7 image"}, out_reg, exp);
    check(busy === 1'b0, "R8 busy low at done", VB'(busy), VB'(0));
    held = out_reg;
    @(negedge clk);
    check(done === 1'b0, "R8 done single", VB'(done), VB'(0));
    repeat (2) @(negedge clk);
    check(out_reg === held, "R10 hold", out_reg, held);
  endtask

  initial begin
    for (int i = 0; i < MF; i++)
      for (int j = 0; j < NB; j++)
        src[(i*NB+j)*8 +: 8] = 8'(i*NB + j + 1);
    repeat (3) @(negedge clk);
    check(out_reg === '0 && busy === 1'b0 && done === 1'b0, "R11 reset", out_reg, '0);
    rst_n = 1;
    for (int v = 0; v < 8; v++)
      run(int'(VEC[v][12:10]), int'(VEC[v][9:8]), int'(VEC[v][7:3]), int'(VEC[v][2:0]),
          "R1 R2 table", 1'b0);
    run(2, 0, 0, 1, "R8 R7 empty chunk", 1'b0);
    run(1, 0, 16, 1, "R9 start while busy", 1'b1);
    run(7, 0, 7, 2, "R5 R7 partial", 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule